// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a small processor core that executes one instruction at a time by stepping a control state machine through up to five states: fetch, decode, execute, memory access and register writeback. A single ALU, one register file and one memory port are shared by all of these states. Each instruction uses only the states it needs, so a branch finishes in three cycles, a store or register-register operation in four, and a load in five. The clock period therefore only has to cover one memory access, one register-file access or one ALU pass, rather than a whole instruction.

The supported instructions are word load, word store, register-register add/sub/and/or/set-less-than, and branch-if-equal. The branch target is computed during decode for every instruction, before the instruction class is known, so that the execute state only has to compare the two operands. The memory sits outside the core behind a single port with a combinational read path and a write that takes effect on the clock edge. Instruction fetches and data accesses share this port. Debug outputs give the current state and a one-cycle pulse when an instruction completes.

Top module: `mc_core`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low) the core is held in the fetch state with PC = 0, and `retire_o` and `mem_we_o` are low.
- R2: In the fetch state `mem_addr_o` equals PC. After any instruction other than a taken branch, the next fetch address is the previous fetch address plus 4.
- R3: `state_o` encodes fetch = 0, decode = 1, execute = 2, memory = 3, writeback = 4. Fetch is always followed by decode. `retire_o` is high for exactly one cycle, in the last state of each instruction, and the next cycle is fetch.
- R4: A load (opcode 0x23) takes 5 cycles and retires in writeback. It writes the memory word at rs + sign-extended imm16 into register rt.
- R5: A store (opcode 0x2B) takes 4 cycles and retires in the memory state. It writes register rt to address rs + sign-extended imm16. `mem_we_o` is high in that memory cycle and in no other cycle.
- R6: A register-register instruction (opcode 0x00) takes 4 cycles. It writes rd with rs op rt, with funct 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R7: A branch-if-equal (opcode 0x04) takes 3 cycles. When rs equals rt the next fetch address is (branch address + 4) + (sign-extended imm16 << 2). Otherwise it is the branch address + 4.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm16 [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | XLEN | Byte address for fetch or data access |
| mem_we_o | output | 1 | Memory write enable, taken at the clock edge |
| mem_wdata_o | output | XLEN | Store data |
| mem_rdata_i | input | XLEN | Read data for `mem_addr_o`, combinational |
| state_o | output | 3 | Current control state |
| retire_o | output | 1 | High in the final cycle of each instruction |

## Verification
Each result has a fixed due cycle counted from the fetch cycle of its instruction, taken as cycle 1. A store's write appears on the memory port in cycle 4. The retire pulse comes in cycle 3, 4 or 5 for a branch, store/arithmetic or load. A branch's effect shows as the fetch address in the cycle after its retire. Register results from loads and arithmetic are only visible through a later store, so each one is checked in that store's memory cycle. The bench samples every output on the falling edge. It follows each instruction from the fetch cycle to the retire cycle, and in every cycle of that span it checks the cycle count, the retire state, the fetch address and any memory write.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BOFS
  } srcb_e;

  localparam int ILEN   = 32;
  localparam int OP_LSB = 26;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int IMM_W  = 16;
  localparam int FN_W   = 6;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2b;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef struct packed {
    logic    ir_we;
    logic    pc_we;           // unconditional PC write
    logic    pc_we_zero;      // PC write qualified by ALU zero
    logic    pc_from_aluout;
    logic    ab_we;
    logic    aluout_we;
    logic    mdr_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
    logic    mem_we;
    logic    mem_from_aluout;
    logic    srca_reg;
    srcb_e   srcb;
    alu_op_e alu_op;
    logic    retire;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra1_i,
  input  logic [REG_AW-1:0] ra2_i,
  output logic [XLEN-1:0]   rd1_o,
  output logic [XLEN-1:0]   rd2_o,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [XLEN-1:0]   wd_i
);
  localparam int NREG = 1 << REG_AW;

  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // register 0 is hardwired to zero
  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [5:0]      opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output state_e          state_o,
  output ctrl_t           ctrl_o
);
  state_e  state_q, state_d;
  alu_op_e fn_op;

  always_comb begin
    case (funct_i)
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.srcb   = SRCB_REG;
    ctrl_o.alu_op = ALU_ADD;
    state_d       = state_q;
    case (state_q)
      ST_FETCH: begin
        ctrl_o.ir_we = 1'b1;
        ctrl_o.pc_we = 1'b1;
        ctrl_o.srcb  = SRCB_FOUR;
        state_d      = ST_DECODE;
      end
      ST_DECODE: begin
        // branch target computed for every class
        ctrl_o.ab_we     = 1'b1;
        ctrl_o.aluout_we = 1'b1;
        ctrl_o.srcb      = SRCB_BOFS;
        state_d          = ST_EXEC;
      end
      ST_EXEC: begin
        case (opcode_i)
          OP_LW, OP_SW: begin
            ctrl_o.srca_reg  = 1'b1;
            ctrl_o.srcb      = SRCB_IMM;
            ctrl_o.aluout_we = 1'b1;
            state_d          = ST_MEM;
          end
          OP_RTYPE: begin
            ctrl_o.srca_reg  = 1'b1;
            ctrl_o.alu_op    = fn_op;
            ctrl_o.aluout_we = 1'b1;
            state_d          = ST_MEM;
          end
          OP_BEQ: begin
            ctrl_o.srca_reg       = 1'b1;
            ctrl_o.alu_op         = ALU_SUB;
            ctrl_o.pc_we_zero     = 1'b1;
            ctrl_o.pc_from_aluout = 1'b1;
            ctrl_o.retire         = 1'b1;
            state_d               = ST_FETCH;
          end
          default: begin
            ctrl_o.retire = 1'b1;
            state_d       = ST_FETCH;
          end
        endcase
      end
      ST_MEM: begin
        case (opcode_i)
          OP_LW: begin
            ctrl_o.mem_from_aluout = 1'b1;
            ctrl_o.mdr_we          = 1'b1;
            state_d                = ST_WB;
          end
          OP_SW: begin
            ctrl_o.mem_from_aluout = 1'b1;
            ctrl_o.mem_we          = 1'b1;
            ctrl_o.retire          = 1'b1;
            state_d                = ST_FETCH;
          end
          default: begin
            ctrl_o.rf_we     = 1'b1;
            ctrl_o.rf_dst_rd = 1'b1;
            ctrl_o.retire    = 1'b1;
            state_d          = ST_FETCH;
          end
        endcase
      end
      ST_WB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_from_mdr = 1'b1;
        ctrl_o.retire      = 1'b1;
        state_d            = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [2:0]      state_o,
  output logic            retire_o
);
  localparam int SX_W = XLEN - IMM_W;

  state_e            state;
  ctrl_t             c;
  logic [ILEN-1:0]   ir_q;
  logic [XLEN-1:0]   pc_q, a_q, b_q, aluout_q, mdr_q;
  logic [XLEN-1:0]   rf_rd1, rf_rd2, rf_wd;
  logic [REG_AW-1:0] rs, rt, rd, rf_wa;
  logic [XLEN-1:0]   imm_sx, br_ofs;
  logic [XLEN-1:0]   alu_a, alu_b, alu_y;
  logic              alu_zero, pc_en;

  assign rs     = ir_q[RS_LSB +: REG_AW];
  assign rt     = ir_q[RT_LSB +: REG_AW];
  assign rd     = ir_q[RD_LSB +: REG_AW];
  assign imm_sx = {{SX_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign br_ofs = {imm_sx[XLEN-3:0], 2'b00};

  mc_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[ILEN-1:OP_LSB]),
    .funct_i  (ir_q[FN_W-1:0]),
    .state_o  (state),
    .ctrl_o   (c)
  );

  assign alu_a = c.srca_reg ? a_q : pc_q;

  always_comb begin
    case (c.srcb)
      SRCB_FOUR: alu_b = XLEN'(4);
      SRCB_IMM:  alu_b = imm_sx;
      SRCB_BOFS: alu_b = br_ofs;
      default:   alu_b = b_q;
    endcase
  end

  mc_alu #(.XLEN(XLEN)) i_alu (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .op_i   (c.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign rf_wa = c.rf_dst_rd ? rd : rt;
  assign rf_wd = c.rf_from_mdr ? mdr_q : aluout_q;

  mc_regfile #(.XLEN(XLEN), .REG_AW(REG_AW)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs),
    .ra2_i  (rt),
    .rd1_o  (rf_rd1),
    .rd2_o  (rf_rd2),
    .we_i   (c.rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  assign pc_en = c.pc_we | (c.pc_we_zero & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_en)       pc_q     <= c.pc_from_aluout ? aluout_q : alu_y;
      if (c.ir_we)     ir_q     <= mem_rdata_i[ILEN-1:0];
      if (c.ab_we)     a_q      <= rf_rd1;
      if (c.ab_we)     b_q      <= rf_rd2;
      if (c.aluout_we) aluout_q <= alu_y;
      if (c.mdr_we)    mdr_q    <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = c.mem_from_aluout ? aluout_q : pc_q;
  assign mem_we_o    = c.mem_we;
  assign mem_wdata_o = b_q;
  assign state_o     = state;
  assign retire_o    = c.retire;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      state_i,
  input logic            retire_i,
  input logic            mem_we_i,
  input logic [XLEN-1:0] mem_addr_i,
  input logic [XLEN-1:0] pc_i,
  input logic [5:0]      opcode_i
);
  assert_state_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 3'd4);

  assert_fetch_then_decode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd0 |=> state_i == 3'd1);

  assert_retire_to_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> (state_i == 3'd0 && !retire_i));

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd0 |-> mem_addr_i == pc_i);

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd0 |=> pc_i == $past(pc_i) + 32'd4);

  assert_write_in_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (state_i == 3'd3 && opcode_i == 6'h2b && retire_i));

  assert_wb_only_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd4 |-> (opcode_i == 6'h23 && retire_i));

  assert_branch_ends_exec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2 && opcode_i == 6'h04) |-> retire_i);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (state_i == 3'd0 && !retire_i && !mem_we_i);
    end
  end
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) i_mc_core_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_o),
  .retire_i   (retire_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .pc_i       (pc_q),
  .opcode_i   (ir_q[31:26])
);

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, retire;
  logic [2:0]  state;
  logic [31:0] mem [0:255];
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mc_core i_mc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .state_o     (state),
    .retire_o    (retire)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  // Called at a falling edge inside the fetch cycle; returns in the next fetch.
  task automatic run_insn(input logic [31:0] exp_pc, input string pc_rq,
                          input int exp_cyc, input string cyc_rq,
                          input bit exp_st, input logic [31:0] exp_a,
                          input logic [31:0] exp_d, input string st_rq);
    int n = 0;
    int seen = 0;
    logic [31:0] wa = '0, wd = '0;
    chk(state == 3'd0, "R3", "state at fetch", 32'(state), 0);
    chk(!retire, "R3", "retire low at fetch", 32'(retire), 0);
    chk(mem_addr == exp_pc, pc_rq, "fetch address", mem_addr, exp_pc);
    forever begin
      n++;
      if (mem_we) begin
        seen++;
        wa = mem_addr;
        wd = mem_wdata;
      end
      if (retire || n >= 12) break;
      @(negedge clk);
    end
    chk(n == exp_cyc, cyc_rq, "cycles to retire", 32'(n), 32'(exp_cyc));
    chk(32'(state) == 32'(exp_cyc - 1), "R3", "state at retire", 32'(state), 32'(exp_cyc - 1));
    if (exp_st) begin
      chk(seen == 1, "R5", "store write count", 32'(seen), 1);
      chk(wa == exp_a, st_rq, "store address", wa, exp_a);
      chk(wd == exp_d, st_rq, "store data", wd, exp_d);
    end else begin
      chk(seen == 0, "R5", "no memory write", 32'(seen), 0);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "R1", "reset state", 32'(state), 0);
    chk(mem_addr == 32'h0, "R1", "reset PC", mem_addr, 0);
    chk(!retire, "R1", "reset retire", 32'(retire), 0);
    chk(!mem_we, "R1", "reset write enable", 32'(mem_we), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_loads(); // R4, R9
    run_insn(32'd0, "R2", 5, "R4", 0, 0, 0, "R4");
    run_insn(32'd4, "R2", 5, "R4", 0, 0, 0, "R4");
  endtask

  task automatic t_arith(); // R6
    for (int i = 0; i < 5; i++)
      run_insn(32'd8 + 32'(4 * i), "R2", 4, "R6", 0, 0, 0, "R6");
    run_insn(32'd28, "R2", 5, "R4", 0, 0, 0, "R4");
    run_insn(32'd32, "R2", 4, "R6", 0, 0, 0, "R6");
  endtask

  task automatic t_stores(); // R5 store, R6 results through stores
    run_insn(32'd36, "R2", 4, "R5", 1, 32'h180, 32'd12, "R6 add");
    run_insn(32'd40, "R2", 4, "R5", 1, 32'h184, 32'd2,  "R6 sub");
    run_insn(32'd44, "R2", 4, "R5", 1, 32'h188, 32'd5,  "R6 and");
    run_insn(32'd48, "R2", 4, "R5", 1, 32'h18c, 32'd7,  "R6 or");
    run_insn(32'd52, "R2", 4, "R5", 1, 32'h190, 32'd1,  "R6 slt true");
    run_insn(32'd56, "R2", 4, "R5", 1, 32'h194, 32'd0,  "R6 slt signed");
  endtask

  task automatic t_r0(); // R8
    run_insn(32'd60, "R2", 4, "R6", 0, 0, 0, "R8");
    run_insn(32'd64, "R2", 4, "R5", 1, 32'h198, 32'd0, "R8 r0 write ignored");
  endtask

  task automatic t_branches(); // R7
    run_insn(32'd68, "R2", 3, "R7", 0, 0, 0, "R7");
    run_insn(32'd72, "R7", 3, "R7", 0, 0, 0, "R7");
    run_insn(32'd84, "R7 taken target", 4, "R5", 1, 32'h1a0, 32'd5, "R5");
  endtask

  task automatic t_offsets(); // R4, R5 with negative offsets
    run_insn(32'd88, "R2", 5, "R4", 0, 0, 0, "R4");
    run_insn(32'd92, "R2", 4, "R5", 1, 32'h1a4, enc_r(1, 2, 3, 6'h20), "R4 negative offset load");
    run_insn(32'd96, "R2", 4, "R5", 1, 32'h004, 32'd7, "R5 negative offset store");
  endtask

  task automatic t_halt_loop(); // R7 backward branch
    run_insn(32'd100, "R2", 3, "R7", 0, 0, 0, "R7");
    run_insn(32'd100, "R7 backward target", 3, "R7", 0, 0, 0, "R7");
    run_insn(32'd100, "R7 backward target", 3, "R7", 0, 0, 0, "R7");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h100);
    mem[1]  = enc_i(6'h23, 0, 2, 16'h104);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(1, 2, 5, 6'h24);
    mem[5]  = enc_r(1, 2, 6, 6'h25);
    mem[6]  = enc_r(2, 1, 7, 6'h2a);
    mem[7]  = enc_i(6'h23, 0, 8, 16'h108);
    mem[8]  = enc_r(1, 8, 9, 6'h2a);
    mem[9]  = enc_i(6'h2b, 0, 3, 16'h180);
    mem[10] = enc_i(6'h2b, 0, 4, 16'h184);
    mem[11] = enc_i(6'h2b, 0, 5, 16'h188);
    mem[12] = enc_i(6'h2b, 0, 6, 16'h18c);
    mem[13] = enc_i(6'h2b, 0, 7, 16'h190);
    mem[14] = enc_i(6'h2b, 0, 9, 16'h194);
    mem[15] = enc_r(1, 2, 0, 6'h20);
    mem[16] = enc_i(6'h2b, 0, 0, 16'h198);
    mem[17] = enc_i(6'h04, 1, 2, 5);
    mem[18] = enc_i(6'h04, 1, 6, 2);
    mem[19] = enc_i(6'h2b, 0, 1, 16'h19c);
    mem[20] = enc_i(6'h2b, 0, 1, 16'h19c);
    mem[21] = enc_i(6'h2b, 0, 2, 16'h1a0);
    mem[22] = enc_i(6'h23, 3, 12, -4);
    mem[23] = enc_i(6'h2b, 0, 12, 16'h1a4);
    mem[24] = enc_i(6'h2b, 3, 1, -8);
    mem[25] = enc_i(6'h04, 0, 0, -1);
    mem[64] = 32'd7;
    mem[65] = 32'd5;
    mem[66] = 32'hffff_fff0;

    t_reset();
    t_loads();
    t_arith();
    t_stores();
    t_r0();
    t_branches();
    t_offsets();
    t_halt_loop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule